// File: doc/BRIEF.md
# Multiplexed I/O Pin Controller

This block controls a bank of I/O pins. Each pin can belong either to general-purpose register logic or to one of four peripheral functions (A, B, C, D). A per-pin ownership bit decides who owns the pin. When the peripherals own it, a two-bit select, with one bit held in each of two select registers, picks which peripheral's output data and output enable reach the pad. When the general-purpose logic owns it, a drive-enable register and a drive-value register set the pad instead.

The pad level is fanned out without delay to the input of every peripheral. The same level also passes through a two-flop synchronizer into a readable level register. A pull-up enable bit per pin goes straight to the pad. Software reaches the registers through a simple one-cycle write port. Each write carries an operation code for plain write, bit set or bit clear, so single bits change without a read-modify-write. Reads are combinational.

Each pin works in one of five modes: GPIO (the ownership bit is 1), or PERIPH_A, PERIPH_B, PERIPH_C or PERIPH_D. The mode is decoded per pin with a case on an enumerated type. The block has no sequencing state: a mode takes effect in the cycle after the register write that selects it.

Top module: `pin_mux_ctrl`

## Requirements
- R1: If a pin's ownership bit is 1, then pad_oe equals its drive-enable bit and pad_out equals its drive-value bit, and the peripheral output and enable inputs have no effect on that pin.
- R2: If a pin's ownership bit is 0, the select {sel_hi, sel_lo} chooses the peripheral: 00 selects A, 01 selects B, 10 selects C and 11 selects D. Peripheral p uses bit p*NPINS+i of per_do and per_oe, and those bits drive pad_out[i] and pad_oe[i].
- R3: Each pin decodes its mode on its own, so different pins can be in different modes at the same time.
- R4: pad_pu follows the pull-up register in every mode.
- R5: Reading address 6 returns pad_in as sampled through two flops. A change on pad_in appears in the read value after two rising edges.
- R6: Every segment of per_di equals pad_in in the same cycle, with no delay.
- R7: After reset the ownership register holds all ones and every other register holds zeros, so pad_oe and pad_pu are zero.
- R8: wr_op 00 writes wr_data, 01 ORs wr_data into the register, 10 clears the bits that are 1 in wr_data, and 11 changes nothing. A write takes effect at the next rising edge.
- R9: Address map: 0 ownership, 1 sel_lo, 2 sel_hi, 3 drive enable, 4 drive value, 5 pull-up, 6 pin level (read only), 7 reads as zero. Writes to addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | Write operation: write, set, clear, none |
| wr_addr | input | 3 | Write register address |
| wr_data | input | NPINS | Write data or bit mask |
| rd_addr | input | 3 | Read register address |
| rd_data | output | NPINS | Read data (combinational) |
| per_do | input | 4*NPINS | Peripheral output data, segments A..D |
| per_oe | input | 4*NPINS | Peripheral output enables, segments A..D |
| per_di | output | 4*NPINS | Pad level fanned to each peripheral |
| pad_in | input | NPINS | Pad input level |
| pad_out | output | NPINS | Pad output level |
| pad_oe | output | NPINS | Pad driver enable |
| pad_pu | output | NPINS | Pad pull-up enable |

## Verification
The bench drives every select code together with peripheral patterns that are distinct in each segment. It also sets up mixed banks where each pin is in a different mode. A design that decoded the select bits in swapped order would put C where B belongs, and a design that let the mux override the ownership bit would leak peripheral data onto GPIO pins. The bench times the level register edge by edge, which catches a synchronizer that is one stage short or one stage long. It also checks that op code 11 and writes to the read-only and unused addresses leave every register unchanged.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int ADDR_W = 3;
    localparam int NPERIPH = 4;
    localparam int NREG = 6;

    localparam logic [ADDR_W-1:0] A_OWN   = 3'd0;
    localparam logic [ADDR_W-1:0] A_SELLO = 3'd1;
    localparam logic [ADDR_W-1:0] A_SELHI = 3'd2;
    localparam logic [ADDR_W-1:0] A_DEN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DVAL  = 3'd4;
    localparam logic [ADDR_W-1:0] A_PULL  = 3'd5;
    localparam logic [ADDR_W-1:0] A_LVL   = 3'd6;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_SET   = 2'b01,
        OP_CLEAR = 2'b10,
        OP_NONE  = 2'b11
    } wr_op_e;

    typedef enum logic [2:0] {
        PERIPH_A = 3'd0,
        PERIPH_B = 3'd1,
        PERIPH_C = 3'd2,
        PERIPH_D = 3'd3,
        GPIO     = 3'd4
    } pin_mode_e;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_op,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NPINS-1:0]     wr_data,
    output logic [NPINS-1:0]     own_q,
    output logic [NPINS-1:0]     sel_lo_q,
    output logic [NPINS-1:0]     sel_hi_q,
    output logic [NPINS-1:0]     drv_en_q,
    output logic [NPINS-1:0]     drv_val_q,
    output logic [NPINS-1:0]     pull_q
);
    logic [NPINS-1:0] bank [NREG];

    function automatic logic [NPINS-1:0] merge(input wr_op_e op,
                                               input logic [NPINS-1:0] old,
                                               input logic [NPINS-1:0] d);
        logic [NPINS-1:0] res;
        unique case (op)
            OP_WRITE: res = d;
            OP_SET:   res = old | d;
            OP_CLEAR: res = old & ~d;
            OP_NONE:  res = old;
            default:  res = old;
        endcase
        return res;
    endfunction

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [NPINS-1:0] RST_VAL = (r == int'(A_OWN)) ? '1 : '0;
        logic [NPINS-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST_VAL;
            end else if (wr_en && wr_addr == ADDR_W'(r)) begin
                q <= merge(wr_op_e'(wr_op), q, wr_data);
            end
        end
        assign bank[r] = q;
    end

    assign own_q     = bank[A_OWN];
    assign sel_lo_q  = bank[A_SELLO];
    assign sel_hi_q  = bank[A_SELHI];
    assign drv_en_q  = bank[A_DEN];
    assign drv_val_q = bank[A_DVAL];
    assign pull_q    = bank[A_PULL];
endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int NPINS = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);
    logic [NPINS-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
    import pinmux_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0]         own_q,
    input  logic [NPINS-1:0]         sel_lo_q,
    input  logic [NPINS-1:0]         sel_hi_q,
    input  logic [NPINS-1:0]         drv_en_q,
    input  logic [NPINS-1:0]         drv_val_q,
    input  logic [NPERIPH*NPINS-1:0] per_do,
    input  logic [NPERIPH*NPINS-1:0] per_oe,
    output logic [NPINS-1:0]         pad_out,
    output logic [NPINS-1:0]         pad_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_mode_e mode;

        always_comb begin
            if (own_q[i]) mode = GPIO;
            else          mode = pin_mode_e'({1'b0, sel_hi_q[i], sel_lo_q[i]});
        end

        always_comb begin
            unique case (mode)
                GPIO: begin
                    pad_out[i] = drv_val_q[i];
                    pad_oe[i]  = drv_en_q[i];
                end
                PERIPH_A: begin
                    pad_out[i] = per_do[0*NPINS+i];
                    pad_oe[i]  = per_oe[0*NPINS+i];
                end
                PERIPH_B: begin
                    pad_out[i] = per_do[1*NPINS+i];
                    pad_oe[i]  = per_oe[1*NPINS+i];
                end
                PERIPH_C: begin
                    pad_out[i] = per_do[2*NPINS+i];
                    pad_oe[i]  = per_oe[2*NPINS+i];
                end
                PERIPH_D: begin
                    pad_out[i] = per_do[3*NPINS+i];
                    pad_oe[i]  = per_oe[3*NPINS+i];
                end
                default: begin
                    pad_out[i] = 1'b0;
                    pad_oe[i]  = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pin_mux_ctrl.sv
module pin_mux_ctrl
    import pinmux_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_op,
    input  logic [2:0]               wr_addr,
    input  logic [NPINS-1:0]         wr_data,
    input  logic [2:0]               rd_addr,
    output logic [NPINS-1:0]         rd_data,
    input  logic [4*NPINS-1:0]       per_do,
    input  logic [4*NPINS-1:0]       per_oe,
    output logic [4*NPINS-1:0]       per_di,
    input  logic [NPINS-1:0]         pad_in,
    output logic [NPINS-1:0]         pad_out,
    output logic [NPINS-1:0]         pad_oe,
    output logic [NPINS-1:0]         pad_pu
);
    logic [NPINS-1:0] own_q, sel_lo_q, sel_hi_q, drv_en_q, drv_val_q, pull_q;
    logic [NPINS-1:0] lvl_q;

    pinmux_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_op    (wr_op),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .own_q    (own_q),
        .sel_lo_q (sel_lo_q),
        .sel_hi_q (sel_hi_q),
        .drv_en_q (drv_en_q),
        .drv_val_q(drv_val_q),
        .pull_q   (pull_q)
    );

    pinmux_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (lvl_q)
    );

    pinmux_route #(.NPINS(NPINS)) u_route (
        .own_q    (own_q),
        .sel_lo_q (sel_lo_q),
        .sel_hi_q (sel_hi_q),
        .drv_en_q (drv_en_q),
        .drv_val_q(drv_val_q),
        .per_do   (per_do),
        .per_oe   (per_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    for (genvar p = 0; p < NPERIPH; p++) begin : g_fan
        assign per_di[p*NPINS +: NPINS] = pad_in;
    end

    assign pad_pu = pull_q;

    always_comb begin
        unique case (rd_addr)
            A_OWN:   rd_data = own_q;
            A_SELLO: rd_data = sel_lo_q;
            A_SELHI: rd_data = sel_hi_q;
            A_DEN:   rd_data = drv_en_q;
            A_DVAL:  rd_data = drv_val_q;
            A_PULL:  rd_data = pull_q;
            A_LVL:   rd_data = lvl_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pin_mux_ctrl_chk.sv
module pin_mux_ctrl_chk #(
    parameter int NPINS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           wr_op,
    input logic [2:0]           wr_addr,
    input logic [NPINS-1:0]     wr_data,
    input logic [4*NPINS-1:0]   per_do,
    input logic [4*NPINS-1:0]   per_oe,
    input logic [NPINS-1:0]     pad_in,
    input logic [NPINS-1:0]     pad_out,
    input logic [NPINS-1:0]     pad_oe,
    input logic [NPINS-1:0]     pad_pu,
    input logic [NPINS-1:0]     own_q,
    input logic [NPINS-1:0]     sel_lo_q,
    input logic [NPINS-1:0]     sel_hi_q,
    input logic [NPINS-1:0]     drv_en_q,
    input logic [NPINS-1:0]     drv_val_q,
    input logic [NPINS-1:0]     pull_q,
    input logic [NPINS-1:0]     lvl_q
);
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_reset_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (own_q == '1 && pad_oe == '0 && pad_pu == '0));

    p_set_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'b01 && wr_addr == 3'd4)
        |=> drv_val_q == ($past(drv_val_q) | $past(wr_data)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'b10 && wr_addr == 3'd3)
        |=> drv_en_q == ($past(drv_en_q) & ~$past(wr_data)));

    p_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_op == 2'b11 || wr_addr[2:1] == 2'b11))
        |=> ($stable(own_q) && $stable(sel_lo_q) && $stable(sel_hi_q)
             && $stable(drv_en_q) && $stable(drv_val_q) && $stable(pull_q)));

    p_pull_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'b01 && wr_addr == 3'd5)
        |=> ((pad_pu & $past(wr_data)) == $past(wr_data)));

    p_sync_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> lvl_q == $past(pad_in, 2));

    p_route_pure_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(own_q) && $stable(sel_lo_q) && $stable(sel_hi_q)
         && $stable(drv_en_q) && $stable(drv_val_q)
         && $stable(per_do) && $stable(per_oe))
        |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind pin_mux_ctrl pin_mux_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_op    (wr_op),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .per_do   (per_do),
    .per_oe   (per_oe),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu),
    .own_q    (own_q),
    .sel_lo_q (sel_lo_q),
    .sel_hi_q (sel_hi_q),
    .drv_en_q (drv_en_q),
    .drv_val_q(drv_val_q),
    .pull_q   (pull_q),
    .lvl_q    (lvl_q)
);

// File: tb/pin_mux_ctrl_tb.sv
`timescale 1ns/1ps
module pin_mux_ctrl_tb;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_op = 2'b00;
    logic [2:0] wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [N-1:0] rd_data;
    logic [4*N-1:0] per_do, per_oe, per_di;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pin_mux_ctrl #(.NPINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .per_do(per_do), .per_oe(per_oe),
        .per_di(per_di), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // Fields: {own, sel_lo, sel_hi, drv_en, drv_val, exp_oe, exp_out}
    localparam logic [27:0] VEC [7] = '{
        28'hF00F6F6, 28'h00000FA, 28'h0F00005, 28'h00F006C,
        28'h0FF0093, 28'h82488DC, 28'h16A010F
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] op, input logic [2:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; wr_op = op; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        per_do = {4'h3, 4'hC, 4'h5, 4'hA};
        per_oe = {4'h9, 4'h6, 4'h0, 4'hF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset values
        rd(3'd0, v); chk("R7 own reset", v, 4'hF);
        for (int a = 1; a < 6; a++) begin
            rd(3'(a), v); chk("R7 reg reset", v, 0);
        end
        chk("R7 pad_oe reset", pad_oe, 0);
        chk("R7 pad_pu reset", pad_pu, 0);

        // R1 R2 R3: mode table
        for (int k = 0; k < 7; k++) begin
            wr(2'b00, 3'd0, VEC[k][27:24]);
            wr(2'b00, 3'd1, VEC[k][23:20]);
            wr(2'b00, 3'd2, VEC[k][19:16]);
            wr(2'b00, 3'd3, VEC[k][15:12]);
            wr(2'b00, 3'd4, VEC[k][11:8]);
            #2;
            chk("R1/R2/R3 pad_oe vector", pad_oe, VEC[k][7:4]);
            chk("R1/R2/R3 pad_out vector", pad_out, VEC[k][3:0]);
        end

        // R1: peripherals ignored on GPIO pins (pin0 is GPIO in last vector)
        per_do = ~per_do; per_oe = ~per_oe;
        #2;
        chk("R1 gpio pin out ignores periph", pad_out[0], 1'b1);
        chk("R1 gpio pin oe ignores periph", pad_oe[0], 1'b0);
        per_do = {4'h3, 4'hC, 4'h5, 4'hA}; per_oe = {4'h9, 4'h6, 4'h0, 4'hF};

        // R8: set / clear / none on drive value
        wr(2'b00, 3'd4, 4'b0001);
        wr(2'b01, 3'd4, 4'b0100);
        rd(3'd4, v); chk("R8 set ORs", v, 4'b0101);
        wr(2'b10, 3'd4, 4'b0001);
        rd(3'd4, v); chk("R8 clear", v, 4'b0100);
        wr(2'b11, 3'd4, 4'b1111);
        rd(3'd4, v); chk("R8 op none", v, 4'b0100);

        // R4: pull-up follows register while peripherals own pins
        wr(2'b00, 3'd0, 4'h0);
        wr(2'b00, 3'd5, 4'b1010);
        chk("R4 pad_pu", pad_pu, 4'b1010);

        // R6: fan-out immediate
        pad_in = 4'b0110;
        #1;
        chk("R6 per_di fanout", per_di, {4{4'b0110}});

        // R5: two-edge latency
        rd(3'd6, v); chk("R5 level before edge", v, 4'b0000);
        @(negedge clk);
        rd(3'd6, v); chk("R5 level after one edge", v, 4'b0000);
        @(negedge clk);
        rd(3'd6, v); chk("R5 level after two edges", v, 4'b0110);

        // R9: writes to 6 and 7 ignored, 7 reads zero
        wr(2'b00, 3'd6, 4'b1001);
        wr(2'b00, 3'd7, 4'b1111);
        rd(3'd6, v); chk("R9 level not writable", v, 4'b0110);
        rd(3'd7, v); chk("R9 addr7 reads zero", v, 0);
        rd(3'd0, v); chk("R9 own untouched", v, 4'h0);
        rd(3'd5, v); chk("R9 pull untouched", v, 4'b1010);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule